// File: doc/BRIEF.md
# Rename Buffer Mapping Unit

This block is the register rename stage of a core that dispatches one integer instruction per cycle. A mapping table with one entry per architectural register records which rename buffer, if any, will hold that register's youngest pending value. A separate rename buffer file holds in-flight results together with a state per buffer. Every dispatched instruction that writes a register is given a fresh buffer, with no check for whether a false dependency exists. Both of its source operands are resolved in the same cycle, either to a buffer tag with a ready flag or to a direct read of the architectural register file.

One execution unit writes results back by buffer tag. Retirement happens in program order. It copies the oldest buffer's result into the architectural register file and frees the buffer. A mapping entry is dropped only when the instruction that owns it retires, and only if no younger rename has replaced it, so later sources fall back to the architectural file. The youngest in-flight instruction can be cancelled. This frees its buffer and puts back the mapping that its rename displaced.

Top module: `rename_unit`

## Requirements
- R1: After reset every buffer is free, every mapping entry is invalid and every architectural register reads zero. So `disp_ready`=1, `ret_ready`=0, and every source lookup reports the architectural file with data 0.
- R2: Buffers are handed out in FIFO order starting at tag 0 and wrapping after NUM_RB-1. `disp_tag` always shows the next tag to be allocated. `disp_ready` is 0 while all NUM_RB buffers are in use or `cancel_valid` is high, and a dispatch with `disp_has_dst`=1 takes effect only when `disp_ready`=1.
- R3: A source whose mapping entry is invalid reports `src_*_arch`=1, `src_*_rdy`=1, `src_*_tag`=0, and the architectural register value as data. A source whose entry is valid reports `src_*_arch`=0 and the mapped buffer tag.
- R4: For a mapped source, `src_*_rdy`=1 with the buffered result as data when the buffer holds a result. Otherwise `src_*_rdy`=0 and the data is 0.
- R5: A result write in the same cycle as a lookup of the same waiting buffer reports the operand ready, with the written data.
- R6: A result write is accepted only by a buffer that is waiting for its result. A write to a free buffer, or to one that already holds a result, changes nothing.
- R7: `ret_ready` is 1 only when the oldest allocated buffer holds its result and no cancel is requested. A retire copies that result into the architectural register of the instruction and frees the buffer.
- R8: At retirement the mapping entry of the destination is cleared only if it still names the retiring buffer. An entry already naming a younger buffer is kept.
- R9: A dispatch points the destination's mapping entry at the new buffer, replacing any older mapping. Sources of that same dispatch see the mapping as it was before the dispatch.
- R10: A cancel with at least one buffer in use frees the youngest buffer and blocks dispatch and retirement in that cycle. It restores the destination's previous mapping when that previous buffer is still allocated, and otherwise leaves the entry invalid. A cancel with no buffer in use has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction presented for dispatch |
| disp_has_dst | input | 1 | Instruction writes a destination register |
| disp_dst | input | log2(NUM_ARCH) | Destination architectural register |
| disp_src_a | input | log2(NUM_ARCH) | First source architectural register |
| disp_src_b | input | log2(NUM_ARCH) | Second source architectural register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | log2(NUM_RB) | Buffer tag given to the next allocation |
| src_a_arch | output | 1 | First source comes from the architectural file |
| src_a_tag | output | log2(NUM_RB) | First source buffer tag (0 when architectural) |
| src_a_rdy | output | 1 | First source value available |
| src_a_data | output | DATA_W | First source value (0 when not ready) |
| src_b_arch | output | 1 | Second source comes from the architectural file |
| src_b_tag | output | log2(NUM_RB) | Second source buffer tag |
| src_b_rdy | output | 1 | Second source value available |
| src_b_data | output | DATA_W | Second source value |
| wb_valid | input | 1 | Result write from the execution unit |
| wb_tag | input | log2(NUM_RB) | Buffer receiving the result |
| wb_data | input | DATA_W | Result value |
| ret_valid | input | 1 | Request to retire the oldest instruction |
| ret_ready | output | 1 | Oldest instruction can retire this cycle |
| cancel_valid | input | 1 | Cancel the youngest in-flight instruction |

## Verification
The bench targets four corner cases.

- **Register renamed twice.** The older instruction is retired first. A design that clears the mapping without comparing the buffer index would then send later readers to a stale architectural value.
- **Result write in the same cycle as a lookup of that buffer.** Without the bypass, the operand is reported as not ready and the consumer misses the wakeup.
- **Cancel after a double rename, and cancel after the displaced buffer has retired.** A wrong design either loses the older mapping or restores a pointer to a freed buffer.
- **Full buffer file with wrapping tags, and result writes to free or finished buffers.** Errors here show up as overwritten live buffers or corrupted retired results.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    typedef enum logic [1:0] {
        BUF_FREE = 2'd0,
        BUF_WAIT = 2'd1,
        BUF_DONE = 2'd2
    } buf_state_e;

endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_RB   = 8,
    parameter int NRD      = 3,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int TW      = $clog2(NUM_RB)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [AW-1:0]            set_reg,
    input  logic [TW-1:0]            set_idx,
    input  logic                     clr_en,
    input  logic [AW-1:0]            clr_reg,
    input  logic [TW-1:0]            clr_idx,
    input  logic                     rsto_en,
    input  logic [AW-1:0]            rsto_reg,
    input  logic                     rsto_vld,
    input  logic [TW-1:0]            rsto_idx,
    input  logic [NRD-1:0][AW-1:0]   rd_reg,
    output logic [NRD-1:0]           rd_vld,
    output logic [NRD-1:0][TW-1:0]   rd_idx
);

    typedef struct packed {
        logic [NUM_ARCH-1:0]         vld;
        logic [NUM_ARCH-1:0][TW-1:0] idx;
    } map_t;

    map_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // retirement drops the entry only if it still names the retiring buffer
        if (clr_en && s_q.vld[clr_reg] && (s_q.idx[clr_reg] == clr_idx)) begin
            s_d.vld[clr_reg] = 1'b0;
            s_d.idx[clr_reg] = '0;
        end
        // cancel puts back the mapping displaced by the youngest rename
        if (rsto_en) begin
            s_d.vld[rsto_reg] = rsto_vld;
            s_d.idx[rsto_reg] = rsto_vld ? rsto_idx : '0;
        end
        // a new rename always wins
        if (set_en) begin
            s_d.vld[set_reg] = 1'b1;
            s_d.idx[set_reg] = set_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_vld[g] = s_q.vld[rd_reg[g]];
        assign rd_idx[g] = s_q.vld[rd_reg[g]] ? s_q.idx[rd_reg[g]] : '0;
    end

    // R9
    set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (s_q.vld[$past(set_reg)] && (s_q.idx[$past(set_reg)] == $past(set_idx))));

    // R8
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && !rsto_en && s_q.vld[clr_reg] && (s_q.idx[clr_reg] != clr_idx))
        |=> (s_q.vld[$past(clr_reg)] && (s_q.idx[$past(clr_reg)] == $past(s_q.idx[clr_reg]))));

endmodule

// File: rtl/rnm_buf_file.sv
module rnm_buf_file
    import rnm_pkg::*;
#(
    parameter int NUM_RB   = 8,
    parameter int NUM_ARCH = 8,
    parameter int DATA_W   = 16,
    parameter int NRD      = 2,
    localparam int TW      = $clog2(NUM_RB),
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int CW      = $clog2(NUM_RB + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic [AW-1:0]                alloc_dst,
    input  logic                         alloc_pv,
    input  logic [TW-1:0]                alloc_pi,
    input  logic                         wb_en,
    input  logic [TW-1:0]                wb_tag,
    input  logic [DATA_W-1:0]            wb_data,
    input  logic                         ret_en,
    input  logic                         cncl_en,
    input  logic [NRD-1:0][TW-1:0]       rd_tag,
    output logic [NRD-1:0]               rd_rdy,
    output logic [NRD-1:0][DATA_W-1:0]   rd_data,
    output logic [TW-1:0]                tail_o,
    output logic [TW-1:0]                head_o,
    output logic                         full_o,
    output logic                         empty_o,
    output logic                         head_done_o,
    output logic [DATA_W-1:0]            head_data_o,
    output logic [AW-1:0]                head_dst_o,
    output logic [AW-1:0]                yng_dst_o,
    output logic                         yng_rvld_o,
    output logic [TW-1:0]                yng_ridx_o
);

    typedef struct packed {
        buf_state_e [NUM_RB-1:0]         st;
        logic [NUM_RB-1:0][DATA_W-1:0]   data;
        logic [NUM_RB-1:0][AW-1:0]       dst;
        logic [NUM_RB-1:0]               pv;
        logic [NUM_RB-1:0][TW-1:0]       pi;
        logic [TW-1:0]                   head;
        logic [TW-1:0]                   tail;
        logic [CW-1:0]                   cnt;
    } bf_t;

    bf_t s_d, s_q;

    function automatic logic [TW-1:0] ptr_inc(input logic [TW-1:0] p);
        return (p == TW'(NUM_RB - 1)) ? '0 : p + TW'(1);
    endfunction

    function automatic logic [TW-1:0] ptr_dec(input logic [TW-1:0] p);
        return (p == '0) ? TW'(NUM_RB - 1) : p - TW'(1);
    endfunction

    logic [TW-1:0] yng;
    logic          cncl_fire;

    assign yng       = ptr_dec(s_q.tail);
    assign cncl_fire = cncl_en && (s_q.cnt != '0);

    always_comb begin
        s_d = s_q;
        // result write: only a waiting buffer takes it, a cancelled one does not
        if (wb_en && (s_q.st[wb_tag] == BUF_WAIT) && !(cncl_fire && (wb_tag == yng))) begin
            s_d.st[wb_tag]   = BUF_DONE;
            s_d.data[wb_tag] = wb_data;
        end
        if (ret_en) begin
            s_d.st[s_q.head] = BUF_FREE;
            s_d.head         = ptr_inc(s_q.head);
        end
        if (alloc_en) begin
            s_d.st[s_q.tail]   = BUF_WAIT;
            s_d.data[s_q.tail] = '0;
            s_d.dst[s_q.tail]  = alloc_dst;
            s_d.pv[s_q.tail]   = alloc_pv;
            s_d.pi[s_q.tail]   = alloc_pi;
            s_d.tail           = ptr_inc(s_q.tail);
        end
        if (cncl_fire) begin
            s_d.st[yng] = BUF_FREE;
            s_d.tail    = yng;
        end
        s_d.cnt = s_q.cnt + CW'(alloc_en) - CW'(ret_en) - CW'(cncl_fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic is_done;
        logic is_byp;
        assign is_done    = (s_q.st[rd_tag[g]] == BUF_DONE);
        assign is_byp     = wb_en && (wb_tag == rd_tag[g]) && (s_q.st[rd_tag[g]] == BUF_WAIT);
        assign rd_rdy[g]  = is_done || is_byp;
        assign rd_data[g] = is_done ? s_q.data[rd_tag[g]] : (is_byp ? wb_data : '0);
    end

    assign tail_o      = s_q.tail;
    assign head_o      = s_q.head;
    assign full_o      = (s_q.cnt == CW'(NUM_RB));
    assign empty_o     = (s_q.cnt == '0);
    assign head_done_o = (s_q.st[s_q.head] == BUF_DONE);
    assign head_data_o = s_q.data[s_q.head];
    assign head_dst_o  = s_q.dst[s_q.head];
    assign yng_dst_o   = s_q.dst[yng];
    assign yng_rvld_o  = s_q.pv[yng] && (s_q.st[s_q.pi[yng]] != BUF_FREE);
    assign yng_ridx_o  = s_q.pi[yng];

    // R2
    alloc_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (s_q.cnt != CW'(NUM_RB)));

    // R2
    alloc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !cncl_en) |=> (s_q.st[$past(s_q.tail)] == BUF_WAIT));

    // R7
    ret_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |-> (s_q.st[s_q.head] == BUF_DONE));

    // R6
    wb_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && (s_q.st[wb_tag] == BUF_FREE)) |=> (s_q.st[$past(wb_tag)] != BUF_DONE));

endmodule

// File: rtl/rnm_arch_file.sv
module rnm_arch_file #(
    parameter int NUM_ARCH = 8,
    parameter int DATA_W   = 16,
    parameter int NRD      = 2,
    localparam int AW      = $clog2(NUM_ARCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_reg,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]      rd_reg,
    output logic [NRD-1:0][DATA_W-1:0]  rd_data
);

    typedef struct packed {
        logic [NUM_ARCH-1:0][DATA_W-1:0] mem;
    } arf_t;

    arf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.mem[wr_reg] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = s_q.mem[rd_reg[g]];
    end

    // R7
    arch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.mem[$past(wr_reg)] == $past(wr_data)));

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_RB   = 8,
    parameter int DATA_W   = 16,
    localparam int AW      = $clog2(NUM_ARCH),
    localparam int TW      = $clog2(NUM_RB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic              disp_has_dst,
    input  logic [AW-1:0]     disp_dst,
    input  logic [AW-1:0]     disp_src_a,
    input  logic [AW-1:0]     disp_src_b,
    output logic              disp_ready,
    output logic [TW-1:0]     disp_tag,
    output logic              src_a_arch,
    output logic [TW-1:0]     src_a_tag,
    output logic              src_a_rdy,
    output logic [DATA_W-1:0] src_a_data,
    output logic              src_b_arch,
    output logic [TW-1:0]     src_b_tag,
    output logic              src_b_rdy,
    output logic [DATA_W-1:0] src_b_data,
    input  logic              wb_valid,
    input  logic [TW-1:0]     wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic              cancel_valid
);

    localparam int NSRC = 2;
    localparam int NMRD = NSRC + 1;

    logic                         full, empty, head_done, yng_rvld;
    logic [TW-1:0]                tail, head, yng_ridx;
    logic [DATA_W-1:0]            head_data;
    logic [AW-1:0]                head_dst, yng_dst;
    logic [NMRD-1:0]              m_vld;
    logic [NMRD-1:0][TW-1:0]      m_idx;
    logic [NSRC-1:0]              b_rdy;
    logic [NSRC-1:0][DATA_W-1:0]  b_data;
    logic [NSRC-1:0][DATA_W-1:0]  a_data;
    logic                         alloc, ret_fire, rsto;

    assign disp_ready = !cancel_valid && !full;
    assign alloc      = disp_valid && disp_ready && disp_has_dst;
    assign ret_ready  = !cancel_valid && head_done;
    assign ret_fire   = ret_valid && ret_ready;
    assign rsto       = cancel_valid && !empty;
    assign disp_tag   = tail;

    rnm_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_RB(NUM_RB), .NRD(NMRD)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (alloc),
        .set_reg  (disp_dst),
        .set_idx  (tail),
        .clr_en   (ret_fire),
        .clr_reg  (head_dst),
        .clr_idx  (head),
        .rsto_en  (rsto),
        .rsto_reg (yng_dst),
        .rsto_vld (yng_rvld),
        .rsto_idx (yng_ridx),
        .rd_reg   ({disp_dst, disp_src_b, disp_src_a}),
        .rd_vld   (m_vld),
        .rd_idx   (m_idx)
    );

    rnm_buf_file #(.NUM_RB(NUM_RB), .NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NRD(NSRC)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (alloc),
        .alloc_dst   (disp_dst),
        .alloc_pv    (m_vld[NSRC]),
        .alloc_pi    (m_idx[NSRC]),
        .wb_en       (wb_valid),
        .wb_tag      (wb_tag),
        .wb_data     (wb_data),
        .ret_en      (ret_fire),
        .cncl_en     (cancel_valid),
        .rd_tag      ({m_idx[1], m_idx[0]}),
        .rd_rdy      (b_rdy),
        .rd_data     (b_data),
        .tail_o      (tail),
        .head_o      (head),
        .full_o      (full),
        .empty_o     (empty),
        .head_done_o (head_done),
        .head_data_o (head_data),
        .head_dst_o  (head_dst),
        .yng_dst_o   (yng_dst),
        .yng_rvld_o  (yng_rvld),
        .yng_ridx_o  (yng_ridx)
    );

    rnm_arch_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NRD(NSRC)) u_arf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ret_fire),
        .wr_reg  (head_dst),
        .wr_data (head_data),
        .rd_reg  ({disp_src_b, disp_src_a}),
        .rd_data (a_data)
    );

    assign src_a_arch = !m_vld[0];
    assign src_a_tag  = m_idx[0];
    assign src_a_rdy  = !m_vld[0] || b_rdy[0];
    assign src_a_data = m_vld[0] ? b_data[0] : a_data[0];
    assign src_b_arch = !m_vld[1];
    assign src_b_tag  = m_idx[1];
    assign src_b_rdy  = !m_vld[1] || b_rdy[1];
    assign src_b_data = m_vld[1] ? b_data[1] : a_data[1];

    // R10
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_valid && empty) |=> ($stable(tail) && $stable(head)));

endmodule

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

    localparam int NA = 8;
    localparam int NB = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid, disp_has_dst;
    logic [2:0]  disp_dst, disp_src_a, disp_src_b;
    logic        disp_ready;
    logic [2:0]  disp_tag;
    logic        src_a_arch, src_a_rdy, src_b_arch, src_b_rdy;
    logic [2:0]  src_a_tag, src_b_tag;
    logic [15:0] src_a_data, src_b_data;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [15:0] wb_data;
    logic        ret_valid, ret_ready, cancel_valid;

    always #10 clk = ~clk;

    rename_unit u_rename_unit (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .src_a_arch(src_a_arch), .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy), .src_a_data(src_a_data),
        .src_b_arch(src_b_arch), .src_b_tag(src_b_tag), .src_b_rdy(src_b_rdy), .src_b_data(src_b_data),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .cancel_valid(cancel_valid)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 0;
    string cur_req = "R1";

    // reference model
    int m_vld [NA];
    int m_idx [NA];
    int arch  [NA];
    int b_st  [NB];
    int b_data[NB];
    int b_dst [NB];
    int b_pv  [NB];
    int b_pi  [NB];
    int head = 0, tail = 0, cnt = 0;

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int lk_arch(int s);  return m_vld[s] ? 0 : 1; endfunction
    function automatic int lk_tag(int s);   return m_vld[s] ? m_idx[s] : 0; endfunction
    function automatic int lk_rdy(int s, int wv, int wt);
        if (!m_vld[s]) return 1;
        return (b_st[m_idx[s]] == 2 || (wv != 0 && wt == m_idx[s] && b_st[m_idx[s]] == 1)) ? 1 : 0;
    endfunction
    function automatic int lk_data(int s, int wv, int wt, int wd);
        if (!m_vld[s]) return arch[s];
        if (b_st[m_idx[s]] == 2) return b_data[m_idx[s]];
        if (wv != 0 && wt == m_idx[s] && b_st[m_idx[s]] == 1) return wd;
        return 0;
    endfunction

    // one cycle: drive after negedge, check mid-cycle, advance model, wait next negedge
    task automatic go(int dv, int hd, int dst, int sa, int sb, int wv, int wt, int wd, int rv, int cv);
        int e_rdy, e_rr, cfire, y, alloc, rfire, wb_ok, pv_new, pi_new, rvld, ridx, hdst;
        disp_valid = 1'(dv); disp_has_dst = 1'(hd); disp_dst = 3'(dst);
        disp_src_a = 3'(sa); disp_src_b = 3'(sb);
        wb_valid = 1'(wv); wb_tag = 3'(wt); wb_data = 16'(wd);
        ret_valid = 1'(rv); cancel_valid = 1'(cv);
        #5;
        e_rdy = (!cv && cnt < NB) ? 1 : 0;
        e_rr  = (!cv && cnt > 0 && b_st[head] == 2) ? 1 : 0;
        chk("disp_ready", int'(disp_ready), e_rdy);
        chk("disp_tag",   int'(disp_tag),   tail);
        chk("ret_ready",  int'(ret_ready),  e_rr);
        chk("src_a_arch", int'(src_a_arch), lk_arch(sa));
        chk("src_a_tag",  int'(src_a_tag),  lk_tag(sa));
        chk("src_a_rdy",  int'(src_a_rdy),  lk_rdy(sa, wv, wt));
        chk("src_a_data", int'(src_a_data), lk_data(sa, wv, wt, wd));
        chk("src_b_arch", int'(src_b_arch), lk_arch(sb));
        chk("src_b_tag",  int'(src_b_tag),  lk_tag(sb));
        chk("src_b_rdy",  int'(src_b_rdy),  lk_rdy(sb, wv, wt));
        chk("src_b_data", int'(src_b_data), lk_data(sb, wv, wt, wd));
        // next state of the model
        cfire = (cv && cnt > 0) ? 1 : 0;
        y     = (tail + NB - 1) % NB;
        alloc = (dv && e_rdy && hd) ? 1 : 0;
        rfire = (rv && e_rr) ? 1 : 0;
        wb_ok = (wv && b_st[wt] == 1 && !(cfire && wt == y)) ? 1 : 0;
        pv_new = m_vld[dst]; pi_new = m_idx[dst];
        rvld = (b_pv[y] && b_st[b_pi[y]] != 0) ? 1 : 0;
        ridx = b_pi[y];
        hdst = b_dst[head];
        if (rfire && m_vld[hdst] && m_idx[hdst] == head) begin m_vld[hdst] = 0; m_idx[hdst] = 0; end
        if (cfire) begin m_vld[b_dst[y]] = rvld; m_idx[b_dst[y]] = rvld ? ridx : 0; end
        if (alloc) begin m_vld[dst] = 1; m_idx[dst] = tail; end
        if (wb_ok) begin b_st[wt] = 2; b_data[wt] = wd; end
        if (rfire) begin arch[hdst] = b_data[head]; b_st[head] = 0; head = (head + 1) % NB; cnt--; end
        if (alloc) begin
            b_st[tail] = 1; b_data[tail] = 0; b_dst[tail] = dst;
            b_pv[tail] = pv_new; b_pi[tail] = pi_new;
            tail = (tail + 1) % NB; cnt++;
        end
        if (cfire) begin b_st[y] = 0; tail = y; cnt--; end
        @(negedge clk);
    endtask

    task automatic idle(int sa, int sb);
        go(0, 0, 0, sa, sb, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20061));
        for (int i = 0; i < NA; i++) begin m_vld[i] = 0; m_idx[i] = 0; arch[i] = 0; end
        for (int i = 0; i < NB; i++) begin b_st[i] = 0; b_data[i] = 0; b_dst[i] = 0; b_pv[i] = 0; b_pi[i] = 0; end
        rst_n = 1'b0;
        disp_valid = 0; disp_has_dst = 0; disp_dst = 0; disp_src_a = 0; disp_src_b = 0;
        wb_valid = 0; wb_tag = 0; wb_data = 0; ret_valid = 0; cancel_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";   // reset state
        idle(0, 7);
        idle(3, 5);

        cur_req = "R9";   // rename, same-dispatch source sees old mapping, re-rename
        go(1, 1, 3, 3, 3, 0, 0, 0, 0, 0);
        go(1, 1, 3, 3, 2, 0, 0, 0, 0, 0);
        idle(3, 2);

        cur_req = "R5";   // write-back bypass into lookup
        go(0, 0, 0, 3, 3, 1, 1, 16'hABCD, 0, 0);

        cur_req = "R6";   // write to finished buffer and to free buffer ignored
        go(0, 0, 0, 3, 0, 1, 1, 16'h1234, 0, 0);
        go(0, 0, 0, 3, 0, 1, 6, 16'h7777, 0, 0);
        idle(3, 0);

        cur_req = "R7";   // retire only when oldest has its result
        go(0, 0, 0, 3, 0, 0, 0, 0, 1, 0);
        go(0, 0, 0, 3, 0, 1, 0, 16'h0055, 0, 0);
        go(0, 0, 0, 3, 0, 0, 0, 0, 1, 0);

        cur_req = "R8";   // younger rename survives older retirement
        idle(3, 3);
        go(0, 0, 0, 3, 0, 0, 0, 0, 1, 0);
        idle(3, 3);

        cur_req = "R10";  // cancel restores, then falls back to unmapped
        go(1, 1, 5, 5, 0, 0, 0, 0, 0, 0);
        go(1, 1, 5, 5, 0, 0, 0, 0, 0, 0);
        go(1, 1, 6, 5, 5, 0, 0, 0, 0, 1);
        idle(5, 6);
        go(0, 0, 0, 5, 0, 0, 0, 0, 0, 1);
        idle(5, 0);
        go(1, 1, 4, 5, 4, 0, 0, 0, 0, 1);
        idle(4, 5);

        cur_req = "R2";   // fill, stall, wrap
        for (int i = 0; i < 9; i++) go(1, 1, i % NA, i % NA, (i + 1) % NA, 0, 0, 0, 0, 0);
        for (int i = 0; i < NB; i++) go(0, 0, 0, i, 0, 1, (head + i) % NB, 16'h100 + i, 0, 0);
        for (int i = 0; i < NB; i++) go(0, 0, 0, i, 7 - i, 0, 0, 0, 1, 0);
        idle(0, 7);

        cur_req = "R3";   // random mix
        for (int n = 0; n < 3000; n++) begin
            int dv, hd, wv, wt, rv, cv;
            dv = ($urandom % 10) < 7 ? 1 : 0;
            hd = ($urandom % 10) < 8 ? 1 : 0;
            wv = ($urandom % 2);
            if (cnt > 0 && ($urandom % 4) != 0) wt = (head + int'($urandom % cnt)) % NB;
            else wt = int'($urandom % NB);
            rv = ($urandom % 10) < 6 ? 1 : 0;
            cv = ($urandom % 25) == 0 ? 1 : 0;
            if (n == 1500) cur_req = "R4";
            go(dv, hd, int'($urandom % NA), int'($urandom % NA), int'($urandom % NA),
               wv, wt, int'($urandom % 65536), rv, cv);
        end

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule